// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Triggers

This block is a register-mapped general-purpose I/O controller for a parameterised number of pins, up to 32. A host reaches it through a single-cycle 32-bit register port. The port carries a byte address, a write strobe, write data and combinational read data. Each pin is an input or an output, set by its direction bit. An output pin drives its value-register bit.

Every pin has its own interrupt trigger. Three per-pin mask registers select the trigger: edge-or-level, polarity, and both-edges. Together they decode into one of five trigger modes: level-low, level-high, falling, rising and any-edge. Pin inputs pass through a two-flop synchroniser. An edge is found by comparing the synchronised value with its value one clock earlier. A trigger sets the pin's pending bit. The host clears a pending bit by writing a one to it. One interrupt line goes high while any pin is both pending and enabled.

A version parameter is readable by the host. It decides whether the both-edges register exists. Without that register, an edge-mode pin sees only the edge that its polarity bit selects.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the enable register (0x08) is 0, the direction register (0x04) is all ones, and the value, pending and mode registers are 0. `irq_out` stays low whenever the enable register is 0.
- R2: A direction bit of 1 makes its pin an input (`pin_oe` bit low). A direction bit of 0 drives `pin_oe` high, and `pin_out` then carries the matching bit of the value register (0x00).
- R3: Reading 0x00 returns, for an input pin, the pin level synchronised through two flops. For an output pin it returns the value-register bit.
- R4: With the edge/level bit (0x18) at 0, the pin is level-triggered. Polarity bit (0x1C) = 1 means active-high and 0 means active-low. The pending bit is set on every clock while the synchronised level is active. After a pin change, the pending bit shows it on the third rising clock edge.
- R5: With the edge/level bit at 1, the pin is edge-triggered. Polarity 1 selects rising edges and 0 selects falling edges. A single matching transition sets the pending bit, and the bit stays set after the pin returns to its previous level.
- R6: When VERSION >= 3, a both-edges bit (0x24) of 1 on an edge-mode pin makes either transition set the pending bit. When VERSION < 3, 0x24 reads 0, writes to it are ignored, and only the polarity-selected edge counts.
- R7: Writing a 1 to a bit of 0x14 clears that pending bit, and writing 0 leaves it unchanged. A trigger in the same cycle as the clear wins, so an active level, or an edge landing on the clear cycle, leaves the bit set.
- R8: 0x10 reads the raw pending bits. 0x0C reads the pending bits ANDed with the enable bits. A pending bit is only ever set by a trigger.
- R9: `irq_out` is high exactly when any pin has both its pending bit and its enable bit set.
- R10: 0x20 reads the VERSION parameter and ignores writes.
- R11: Read bits at and above PINS are 0 for every address except 0x20, and write-data bits at and above PINS have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | PINS | Asynchronous pin levels |
| pin_out | output | PINS | Output levels from the value register |
| pin_oe | output | PINS | Output enable, high for output pins |
| irq_out | output | 1 | Combined interrupt to the host |

## Verification
The hardest situation to reach from the ports is a clear write that lands on the very clock edge where an edge trigger sets the same pending bit. The stimulus drives the pin on a falling clock edge and waits one full cycle. It then places the clear write so that its strobe is sampled on the third rising edge after the pin change, which is the edge on which the synchronised transition reaches the pending register. A level-high pin is also held active across a clear, to show that the bit re-sets at once. A second instance, built with a version below 3, shows that the both-edges register is absent.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_VALUE = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_ISTAT = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_IPEND = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_ICLR  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_EDGE  = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_POL   = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_VER   = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_BOTH  = 6'h24;

    // First version that carries the both-edges register
    localparam int unsigned BOTH_MIN_VER = 3;

    typedef enum logic [2:0] {
        TRG_LVL_LO = 3'd0,
        TRG_LVL_HI = 3'd1,
        TRG_FALL   = 3'd2,
        TRG_RISE   = 3'd3,
        TRG_BOTH   = 3'd4
    } trig_mode_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_q,
    output logic [W-1:0] prev_q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_irq_pkg::*;
(
    input  logic cur,
    input  logic prev,
    input  logic edge_sel,
    input  logic pol_sel,
    input  logic both_sel,
    output logic hit
);
    trig_mode_e mode;

    always_comb begin
        if (!edge_sel)
            mode = pol_sel ? TRG_LVL_HI : TRG_LVL_LO;
        else if (both_sel)
            mode = TRG_BOTH;
        else
            mode = pol_sel ? TRG_RISE : TRG_FALL;
    end

    always_comb begin
        unique case (mode)
            TRG_LVL_LO: hit = ~cur;
            TRG_LVL_HI: hit = cur;
            TRG_FALL:   hit = prev & ~cur;
            TRG_RISE:   hit = cur & ~prev;
            TRG_BOTH:   hit = cur ^ prev;
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS    = 16,
    parameter int unsigned VERSION = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq_out
);
    localparam bit HAS_BOTH = (VERSION >= BOTH_MIN_VER);

    logic [PINS-1:0] wd;
    logic [PINS-1:0] val_q, dir_q, en_q, edge_q, pol_q, both_q, pend_q;
    logic [PINS-1:0] sync_v, prev_v, set_vec, clr_vec, rd_vec;

    assign wd = bus_wdata[PINS-1:0];

    generate
        if (PINS < 32) begin : g_hi_unused
            logic unused_hi;
            assign unused_hi = ^bus_wdata[31:PINS];
        end
    endgenerate

    gpio_pin_sync #(.W(PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (pin_in),
        .sync_q (sync_v),
        .prev_q (prev_v)
    );

    generate
        for (genvar i = 0; i < PINS; i++) begin : g_det
            gpio_trig_detect u_det (
                .cur      (sync_v[i]),
                .prev     (prev_v[i]),
                .edge_sel (edge_q[i]),
                .pol_sel  (pol_q[i]),
                .both_sel (both_q[i]),
                .hit      (set_vec[i])
            );
        end
    endgenerate

    assign clr_vec = (bus_we && bus_addr == OFS_ICLR) ? wd : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q  <= '0;
            dir_q  <= '1;
            en_q   <= '0;
            edge_q <= '0;
            pol_q  <= '0;
            pend_q <= '0;
        end else begin
            // a trigger outranks a clear in the same cycle
            pend_q <= (pend_q & ~clr_vec) | set_vec;
            if (bus_we) begin
                case (bus_addr)
                    OFS_VALUE: val_q  <= wd;
                    OFS_DIR:   dir_q  <= wd;
                    OFS_IEN:   en_q   <= wd;
                    OFS_EDGE:  edge_q <= wd;
                    OFS_POL:   pol_q  <= wd;
                    default:   ;
                endcase
            end
        end
    end

    generate
        if (HAS_BOTH) begin : g_both
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    both_q <= '0;
                else if (bus_we && bus_addr == OFS_BOTH)
                    both_q <= wd;
            end
        end else begin : g_no_both
            assign both_q = '0;
        end
    endgenerate

    always_comb begin
        case (bus_addr)
            OFS_VALUE: rd_vec = (dir_q & sync_v) | (~dir_q & val_q);
            OFS_DIR:   rd_vec = dir_q;
            OFS_IEN:   rd_vec = en_q;
            OFS_ISTAT: rd_vec = pend_q & en_q;
            OFS_IPEND: rd_vec = pend_q;
            OFS_EDGE:  rd_vec = edge_q;
            OFS_POL:   rd_vec = pol_q;
            OFS_BOTH:  rd_vec = both_q;
            default:   rd_vec = '0;
        endcase
        bus_rdata = '0;
        bus_rdata[PINS-1:0] = rd_vec;
        if (bus_addr == OFS_VER)
            bus_rdata = 32'(VERSION);
    end

    assign pin_out = val_q;
    assign pin_oe  = ~dir_q;
    assign irq_out = |(pend_q & en_q);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS    = 16,
    parameter int unsigned VERSION = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [5:0]      bus_addr,
    input logic            bus_we,
    input logic [31:0]     bus_wdata,
    input logic [31:0]     bus_rdata,
    input logic            irq_out,
    input logic [PINS-1:0] en_q,
    input logic [PINS-1:0] pend_q,
    input logic [PINS-1:0] set_vec
);
    // R1
    no_irq_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_out);

    // R7
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_ICLR) |=>
        ((pend_q & $past(bus_wdata[PINS-1:0]) & ~$past(set_vec)) == '0));

    // R4
    trigger_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> (($past(set_vec) & ~pend_q) == '0));

    // R8
    pend_only_by_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0));

    // R9
    irq_matches_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_ISTAT) |-> (irq_out == (bus_rdata != 32'd0)));

    // R10
    version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_VER) |-> (bus_rdata == 32'(VERSION)));

    generate
        if (PINS < 32) begin : g_hi
            // R11
            upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_addr != OFS_VER) |-> (bus_rdata[31:PINS] == '0));
        end
    endgenerate
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.PINS(PINS), .VERSION(VERSION)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .en_q      (en_q),
    .pend_q    (pend_q),
    .set_vec   (set_vec)
);

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
    localparam int N = 16;
    localparam int VER = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] addr = '0;
    logic we = 1'b0;
    logic [31:0] wdata = '0;
    logic [N-1:0] pin = '0;
    wire [31:0] rdata;
    wire [N-1:0] pout, poe;
    wire irq;

    logic [5:0] l_addr = '0;
    logic l_we = 1'b0;
    logic [31:0] l_wdata = '0;
    logic [7:0] l_pin = '0;
    wire [31:0] l_rdata;
    wire [7:0] l_pout, l_poe;
    wire l_irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_ctrl #(.PINS(N), .VERSION(VER)) u_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .pin_in(pin), .pin_out(pout), .pin_oe(poe), .irq_out(irq));

    gpio_irq_ctrl #(.PINS(8), .VERSION(2)) u_gpio_irq_ctrl_v2 (
        .clk(clk), .rst_n(rst_n), .bus_addr(l_addr), .bus_we(l_we), .bus_wdata(l_wdata),
        .bus_rdata(l_rdata), .pin_in(l_pin), .pin_out(l_pout), .pin_oe(l_poe), .irq_out(l_irq));

    // behavioural reference of the main instance
    bit [N-1:0] m_s1, m_s2, m_prev, m_val, m_dir, m_en, m_pend, m_edge, m_pol, m_both;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_val = '0; m_dir = '1;
            m_en = '0; m_pend = '0; m_edge = '0; m_pol = '0; m_both = '0;
        end else begin
            bit [N-1:0] hits;
            bit [N-1:0] clr;
            hits = '0;
            for (int i = 0; i < N; i++) begin
                if (!m_edge[i])
                    hits[i] = (m_s2[i] == m_pol[i]);
                else if (m_both[i])
                    hits[i] = (m_s2[i] != m_prev[i]);
                else if (m_pol[i])
                    hits[i] = m_s2[i] && !m_prev[i];
                else
                    hits[i] = !m_s2[i] && m_prev[i];
            end
            clr = (we && addr == 6'h14) ? wdata[N-1:0] : '0;
            for (int i = 0; i < N; i++)
                if (hits[i]) m_pend[i] = 1'b1;
                else if (clr[i]) m_pend[i] = 1'b0;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
            if (we) begin
                case (addr)
                    6'h00: m_val  = wdata[N-1:0];
                    6'h04: m_dir  = wdata[N-1:0];
                    6'h08: m_en   = wdata[N-1:0];
                    6'h18: m_edge = wdata[N-1:0];
                    6'h1C: m_pol  = wdata[N-1:0];
                    6'h24: m_both = wdata[N-1:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [5:0] a);
        bit [N-1:0] v;
        case (a)
            6'h00: for (int i = 0; i < N; i++) v[i] = m_dir[i] ? m_s2[i] : m_val[i];
            6'h04: v = m_dir;
            6'h08: v = m_en;
            6'h0C: v = m_pend & m_en;
            6'h10: v = m_pend;
            6'h18: v = m_edge;
            6'h1C: v = m_pol;
            6'h24: v = m_both;
            default: v = '0;
        endcase
        if (a == 6'h20) return 32'(VER);
        return {{(32-N){1'b0}}, v};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 irq_out", {31'd0, irq}, {31'd0, |(m_pend & m_en)});
            chk("R2 pin_out", {16'd0, pout}, {16'd0, m_val});
            chk("R2 pin_oe", {16'd0, poe}, {16'd0, ~m_dir});
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input string req);
        @(negedge clk); addr = a; we = 1'b0;
        #2 chk(req, rdata, model_read(a));
    endtask

    task automatic lwr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); l_addr = a; l_wdata = d; l_we = 1'b1;
        @(negedge clk); l_we = 1'b0;
    endtask

    task automatic lrd(input logic [5:0] a, input logic [31:0] mask, input logic [31:0] exp, input string req);
        @(negedge clk); l_addr = a; l_we = 1'b0;
        #2 chk(req, l_rdata & mask, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_err++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(6'h08, "R1 ien reset"); chk("R1 ien zero", rdata, 32'h0);
        rd(6'h04, "R1 dir reset"); chk("R1 dir ones", rdata, 32'h0000_FFFF);
        rd(6'h00, "R1 value reset");
        rd(6'h18, "R1 edge reset");
        rd(6'h10, "R8 pend after reset");
        // R10 version, read-only
        wr(6'h20, 32'h0000_00FF);
        rd(6'h20, "R10 version"); chk("R10 version literal", rdata, 32'd3);
        // R2 / R3 direction and value
        wr(6'h04, 32'h0000_FF00);
        wr(6'h00, 32'h0000_A5C3);
        pin = 16'h5A3C;
        idle(3);
        rd(6'h00, "R3 mixed value read");
        chk("R3 mixed literal", rdata, 32'h0000_5AC3);
        wr(6'h04, 32'h0000_FFFF);
        rd(6'h00, "R3 all inputs");
        // R4 level-high on all pins
        pin = 16'h0000;
        wr(6'h1C, 32'h0000_FFFF);
        idle(3);
        wr(6'h14, 32'h0000_FFFF);
        rd(6'h10, "R4 no pending with inactive level");
        wr(6'h08, 32'hFFFF_FFFF);
        rd(6'h08, "R11 upper enable bits dropped"); chk("R11 enable literal", rdata, 32'h0000_FFFF);
        pin = 16'h0011;
        idle(4);
        rd(6'h10, "R4 level-high pending");
        rd(6'h0C, "R8 status");
        // R7 clear while the level persists
        wr(6'h14, 32'h0000_0011);
        rd(6'h10, "R7 level holds through clear"); chk("R7 level literal", rdata & 32'h11, 32'h11);
        pin = 16'h0000;
        idle(3);
        wr(6'h14, 32'h0000_0001);
        rd(6'h10, "R7 only written bit cleared");
        wr(6'h14, 32'h0000_0000);
        rd(6'h10, "R7 zero write no effect");
        wr(6'h14, 32'h0000_0010);
        // R4 level-low on pin 3
        wr(6'h1C, 32'h0000_FFF7);
        idle(3);
        rd(6'h10, "R4 level-low pending");
        wr(6'h1C, 32'h0000_FFFF);
        wr(6'h14, 32'h0000_FFFF);
        // R5 edge: pin 9 rising, pin 10 falling
        pin = 16'h0400;
        wr(6'h18, 32'h0000_0E00);
        wr(6'h1C, 32'h0000_FBFF);
        idle(3);
        wr(6'h14, 32'h0000_FFFF);
        rd(6'h10, "R5 edge pins idle");
        pin = 16'h0200;
        idle(4);
        rd(6'h10, "R5 rise and fall");
        chk("R5 edge literal", rdata & 32'h0600, 32'h0600);
        pin = 16'h0400;
        idle(4);
        rd(6'h10, "R5 pending stays after return");
        wr(6'h14, 32'h0000_0600);
        // R6 both edges on pin 11
        wr(6'h24, 32'h0000_0800);
        rd(6'h24, "R6 both register");
        pin = 16'h0C00;
        idle(4);
        rd(6'h10, "R6 rising counts");
        wr(6'h14, 32'h0000_0800);
        pin = 16'h0400;
        idle(4);
        rd(6'h10, "R6 falling counts");
        chk("R6 both literal", rdata & 32'h0800, 32'h0800);
        wr(6'h14, 32'h0000_FFFF);
        // R7 clear coincident with an edge on pin 9
        pin = 16'h0600;
        @(negedge clk);
        wr(6'h14, 32'h0000_0200);
        rd(6'h10, "R7 set beats clear");
        chk("R7 set beats clear literal", rdata & 32'h0200, 32'h0200);
        wr(6'h14, 32'h0000_0200);
        rd(6'h10, "R7 later clear");
        rd(6'h0C, "R8 status after clears");
        wr(6'h08, 32'h0);
        rd(6'h0C, "R8 status masked");
        rd(6'h30, "R11 unmapped address");

        // legacy instance without both-edges register (R6)
        lwr(6'h24, 32'h0000_00FF);
        lrd(6'h24, 32'hFFFF_FFFF, 32'h0, "R6 no both register");
        lrd(6'h20, 32'hFFFF_FFFF, 32'd2, "R10 legacy version");
        lwr(6'h18, 32'h0000_00FF);
        lwr(6'h1C, 32'h0000_00FF);
        l_pin = 8'h01;
        idle(4);
        lrd(6'h10, 32'h1, 32'h1, "R5 legacy rising");
        lwr(6'h14, 32'h0000_00FF);
        lrd(6'h10, 32'h1, 32'h0, "R7 legacy clear");
        l_pin = 8'h00;
        idle(4);
        lrd(6'h10, 32'h1, 32'h0, "R6 legacy falling ignored");
        idle(2);
        finish_run();
    end
endmodule